// File: doc/BRIEF.md
# Flash Read Clock Divider Calibration Sequencer

This block runs the clock-divider part of a read-timing calibration for one serial flash device. On a start pulse it takes a snapshot of the stored control-word variants. It writes the read variant to the controller with the divider field cleared, which is the slowest setting, and asks an external read unit to capture a reference region. The words of that region come back as a 32-bit stream. The block counts how many of them carry real content, meaning they are neither all zeros nor all ones. If there are too few, calibration stops at once.

If the reference data is varied enough, the sequencer tries each clock divider in turn, from the slowest toward the fastest allowed. It skips any divider that would clock the device above its rated maximum. For each divider that remains, it programs the control word and starts an external delay-search sub-block. The last divider that passes is the fastest working one. That divider is folded into every stored variant, and the read variant is written back to the controller. A done pulse and one of three result flags close each run.

Top module: `clkcal_seq`

## Requirements
- R1: On an accepted start, the first control write is the read variant (index READ_IDX) with bits 11:8 cleared, and with bits 27:24 also cleared when WIDE_MASK is set. A capture request pulse goes out in the same cycle.
- R2: Only stream words that arrive while the capture is in progress are counted, and the capture ends after REGION_BYTES/4 valid words. Calibration proceeds only if at least THRESH of those words are neither 0x00000000 nor 0xFFFFFFFF. Words seen while idle and cycles with the valid input low have no effect.
- R3: If the reference data is too uniform, no search starts. The original read variant is written back, the variant outputs are left unchanged and too_uniform_o is set.
- R4: Dividers are tried in the order 5 down to MIN_DIV. Each divider tried gets one control write with its code in bits 11:8 and one search start that carries the divider. The codes for divide-by-1 through divide-by-5 are 0xF, 0x7, 0xE, 0x6 and 0xD.
- R5: A divider d is skipped, with no write and no search, when dev_max_mhz_i × d < bus_mhz_i. Equality counts as allowed.
- R6: When several dividers pass, the smallest one wins and is reported on best_div_o.
- R7: On success, every variant output has its divider field (bits 11:8) replaced with the winning code, and its other bits are masked as in R1. The updated read variant is the last control write, and cal_ok_o is set.
- R8: If no divider passes, or none is allowed, no_div_o is set, best_div_o is 0, the variants are left unchanged and the original read variant is written last.
- R9: busy_o stays high from an accepted start until done_o, which is a one-cycle pulse. A start pulse during a run has no effect, and exactly one result flag is set at done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start calibration pulse |
| bus_mhz_i | input | FREQ_W | Bus clock frequency, held for the whole run |
| dev_max_mhz_i | input | FREQ_W | Device maximum frequency, held for the whole run |
| ctrl_var_i | input | NUM_VAR*32 | Stored control-word variants, variant i in bits 32i+31:32i |
| ctrl_wr_o | output | 1 | Controller control-word write strobe |
| ctrl_wdata_o | output | 32 | Control word to write |
| cap_req_o | output | 1 | Reference capture request pulse |
| word_valid_i | input | 1 | Stream word valid |
| word_i | input | 32 | Stream word |
| search_start_o | output | 1 | Delay-search start pulse |
| search_div_o | output | 3 | Divider under search |
| search_done_i | input | 1 | Delay search finished |
| search_pass_i | input | 1 | Delay search found a working setting |
| ctrl_var_o | output | NUM_VAR*32 | Calibrated control-word variants |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished pulse |
| cal_ok_o | output | 1 | A divider was found |
| too_uniform_o | output | 1 | Reference data rejected |
| no_div_o | output | 1 | No divider passed |
| best_div_o | output | 3 | Winning divider, 0 if none |

## Verification
The bench targets the uniformity threshold at exactly THRESH-1 and THRESH content words. A counter that is off by one, or that also counts idle or non-valid words, would accept or reject the wrong region. It sweeps all 32 pass patterns of the five dividers against device limits that allow all, some, exactly-equal or no dividers. A design with a reversed loop, a wrong code table, a strict comparison or a first-pass-wins rule would then write different control words, search different dividers or report a different best divider. A start pulse injected mid-capture would reveal a sequencer that restarts.

// File: rtl/clkcal_pkg.sv
package clkcal_pkg;
  localparam int DIV_TOP   = 5;
  localparam int DIV_W     = 3;
  localparam int FIELD_LSB = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_CAP, S_PICK, S_WAIT, S_NEXT, S_FOLD, S_FIN
  } cal_state_e;

  // divider field codes are not monotonic in the divide ratio
  function automatic logic [3:0] div_code(input logic [DIV_W-1:0] d);
    case (d)
      3'd1: div_code = 4'hF;
      3'd2: div_code = 4'h7;
      3'd3: div_code = 4'hE;
      3'd4: div_code = 4'h6;
      3'd5: div_code = 4'hD;
      default: div_code = 4'h0;
    endcase
  endfunction

  function automatic logic [31:0] cal_mask(input bit wide);
    cal_mask = wide ? 32'hF0FF_F0FF : 32'hFFFF_F0FF;
  endfunction
endpackage

// File: rtl/clkcal_scan.sv
module clkcal_scan #(
  parameter int WORDS  = 4096,
  parameter int THRESH = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic        valid_i,
  input  logic [31:0] word_i,
  output logic        done_o,
  output logic        ok_o
);
  localparam int WCW = $clog2(WORDS + 1);
  localparam int TCW = $clog2(THRESH + 1);

  logic [WCW-1:0] wcnt_q;
  logic [TCW-1:0] ncnt_q;
  logic           enough_q;
  logic           take, varied;

  assign take   = en_i && valid_i && (wcnt_q != WCW'(WORDS));
  assign varied = (word_i != 32'h0000_0000) && (word_i != 32'hFFFF_FFFF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q   <= '0;
      ncnt_q   <= '0;
      enough_q <= 1'b0;
    end else if (clr_i) begin
      wcnt_q   <= '0;
      ncnt_q   <= '0;
      enough_q <= 1'b0;
    end else if (take) begin
      wcnt_q <= wcnt_q + 1'b1;
      // saturate once the threshold is met; early accept
      if (varied && !enough_q) begin
        ncnt_q <= ncnt_q + 1'b1;
        if (ncnt_q == TCW'(THRESH - 1)) enough_q <= 1'b1;
      end
    end
  end

  assign done_o = (wcnt_q == WCW'(WORDS));
  assign ok_o   = enough_q;

  p_enough_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enough_q && !clr_i) |=> enough_q);
  p_cnt_sat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enough_q |-> (ncnt_q == TCW'(THRESH)));
endmodule

// File: rtl/clkcal_gate.sv
module clkcal_gate #(
  parameter int FREQ_W = 16
) (
  input  logic [FREQ_W-1:0] bus_i,
  input  logic [FREQ_W-1:0] max_i,
  input  logic [2:0]        div_i,
  output logic              ok_o,
  output logic [3:0]        code_o
);
  import clkcal_pkg::*;
  localparam int PW = FREQ_W + 3;

  logic [PW-1:0] prod;

  // bus/div <= max  <=>  max*div >= bus, no divider needed
  assign prod   = PW'(max_i) * PW'(div_i);
  assign ok_o   = (prod >= PW'(bus_i));
  assign code_o = div_code(div_i);
endmodule

// File: rtl/clkcal_fold.sv
module clkcal_fold #(
  parameter int          NUM_VAR = 3,
  parameter logic [31:0] FMASK   = 32'hFFFF_F0FF
) (
  input  logic [NUM_VAR-1:0][31:0] var_i,
  input  logic [3:0]               code_i,
  output logic [NUM_VAR-1:0][31:0] var_o
);
  import clkcal_pkg::*;

  for (genvar g = 0; g < NUM_VAR; g++) begin : g_var
    assign var_o[g] = (var_i[g] & FMASK) | (32'(code_i) << FIELD_LSB);
  end
endmodule

// File: rtl/clkcal_seq.sv
module clkcal_seq #(
  parameter int NUM_VAR      = 3,
  parameter int READ_IDX     = 1,
  parameter int REGION_BYTES = 16384,
  parameter int THRESH       = 64,
  parameter int MIN_DIV      = 1,
  parameter bit WIDE_MASK    = 1'b0,
  parameter int FREQ_W       = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [FREQ_W-1:0]      bus_mhz_i,
  input  logic [FREQ_W-1:0]      dev_max_mhz_i,
  input  logic [NUM_VAR*32-1:0]  ctrl_var_i,
  output logic                   ctrl_wr_o,
  output logic [31:0]            ctrl_wdata_o,
  output logic                   cap_req_o,
  input  logic                   word_valid_i,
  input  logic [31:0]            word_i,
  output logic                   search_start_o,
  output logic [2:0]             search_div_o,
  input  logic                   search_done_i,
  input  logic                   search_pass_i,
  output logic [NUM_VAR*32-1:0]  ctrl_var_o,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   cal_ok_o,
  output logic                   too_uniform_o,
  output logic                   no_div_o,
  output logic [2:0]             best_div_o
);
  import clkcal_pkg::*;

  localparam int          WORDS = REGION_BYTES / 4;
  localparam logic [31:0] FMASK = cal_mask(WIDE_MASK);
  localparam logic [2:0]  DMIN  = 3'(MIN_DIV);
  localparam logic [2:0]  DMAX  = 3'(DIV_TOP);

  cal_state_e               st_q;
  logic [NUM_VAR-1:0][31:0] var_q, var_in, var_fold;
  logic [2:0]               div_q, best_q;
  logic                     scan_clr, scan_en, scan_done, scan_ok;
  logic                     div_ok;
  logic [3:0]               div_enc, best_enc;

  for (genvar g = 0; g < NUM_VAR; g++) begin : g_io
    assign var_in[g]              = ctrl_var_i[g*32 +: 32];
    assign ctrl_var_o[g*32 +: 32] = var_q[g];
  end

  assign scan_clr = (st_q == S_IDLE) && start_i;
  assign scan_en  = (st_q == S_CAP);
  assign best_enc = div_code(best_q);

  clkcal_scan #(.WORDS(WORDS), .THRESH(THRESH)) u_scan (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (scan_clr),
    .en_i    (scan_en),
    .valid_i (word_valid_i),
    .word_i  (word_i),
    .done_o  (scan_done),
    .ok_o    (scan_ok)
  );

  clkcal_gate #(.FREQ_W(FREQ_W)) u_gate (
    .bus_i  (bus_mhz_i),
    .max_i  (dev_max_mhz_i),
    .div_i  (div_q),
    .ok_o   (div_ok),
    .code_o (div_enc)
  );

  clkcal_fold #(.NUM_VAR(NUM_VAR), .FMASK(FMASK)) u_fold (
    .var_i  (var_q),
    .code_i (best_enc),
    .var_o  (var_fold)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q           <= S_IDLE;
      var_q          <= '0;
      div_q          <= DMAX;
      best_q         <= '0;
      ctrl_wr_o      <= 1'b0;
      ctrl_wdata_o   <= '0;
      cap_req_o      <= 1'b0;
      search_start_o <= 1'b0;
      search_div_o   <= '0;
      busy_o         <= 1'b0;
      done_o         <= 1'b0;
      cal_ok_o       <= 1'b0;
      too_uniform_o  <= 1'b0;
      no_div_o       <= 1'b0;
    end else begin
      ctrl_wr_o      <= 1'b0;
      cap_req_o      <= 1'b0;
      search_start_o <= 1'b0;
      done_o         <= 1'b0;
      case (st_q)
        S_IDLE: if (start_i) begin
          var_q         <= var_in;
          ctrl_wr_o     <= 1'b1;
          ctrl_wdata_o  <= var_in[READ_IDX] & FMASK;
          cap_req_o     <= 1'b1;
          div_q         <= DMAX;
          best_q        <= '0;
          cal_ok_o      <= 1'b0;
          too_uniform_o <= 1'b0;
          no_div_o      <= 1'b0;
          busy_o        <= 1'b1;
          st_q          <= S_CAP;
        end
        S_CAP: if (scan_done) begin
          if (scan_ok) begin
            st_q <= S_PICK;
          end else begin
            ctrl_wr_o     <= 1'b1;
            ctrl_wdata_o  <= var_q[READ_IDX];
            too_uniform_o <= 1'b1;
            st_q          <= S_FIN;
          end
        end
        S_PICK: begin
          if (div_ok) begin
            ctrl_wr_o      <= 1'b1;
            ctrl_wdata_o   <= (var_q[READ_IDX] & FMASK) | (32'(div_enc) << FIELD_LSB);
            search_start_o <= 1'b1;
            search_div_o   <= div_q;
            st_q           <= S_WAIT;
          end else begin
            st_q <= S_NEXT;
          end
        end
        S_WAIT: if (search_done_i) begin
          if (search_pass_i) best_q <= div_q;
          st_q <= S_NEXT;
        end
        S_NEXT: begin
          if (div_q == DMIN) begin
            st_q <= S_FOLD;
          end else begin
            div_q <= div_q - 1'b1;
            st_q  <= S_PICK;
          end
        end
        S_FOLD: begin
          ctrl_wr_o <= 1'b1;
          if (best_q != '0) begin
            var_q        <= var_fold;
            ctrl_wdata_o <= var_fold[READ_IDX];
            cal_ok_o     <= 1'b1;
          end else begin
            ctrl_wdata_o <= var_q[READ_IDX];
            no_div_o     <= 1'b1;
          end
          st_q <= S_FIN;
        end
        S_FIN: begin
          done_o <= 1'b1;
          busy_o <= 1'b0;
          st_q   <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign best_div_o = best_q;

  p_cap_masked_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_req_o |-> (ctrl_wr_o && ((ctrl_wdata_o & ~FMASK) == 32'h0)));
  p_search_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    search_start_o |-> (ctrl_wr_o && (ctrl_wdata_o[11:8] == div_code(search_div_o))));
  p_search_allowed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    search_start_o |-> $past(div_ok));
  p_best_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cal_ok_o) |-> (best_div_o >= DMIN && best_div_o <= DMAX));
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_one_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($countones({cal_ok_o, too_uniform_o, no_div_o}) == 1 && !busy_o));
endmodule

// File: tb/tb_clkcal_seq.sv
module tb_clkcal_seq;
  localparam int NV    = 3;
  localparam int RIDX  = 1;
  localparam int RB    = 512;
  localparam int TH    = 64;
  localparam int MIND  = 1;
  localparam int FW    = 16;
  localparam int WORDS = RB / 4;
  localparam logic [31:0] MASK = 32'hF0FF_F0FF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [FW-1:0] bus_i = '0, max_i = '0;
  logic [NV*32-1:0] var_i = '0;
  logic wr_o, cap_o, sst_o, busy_o, done_o, ok_o, uni_o, nod_o;
  logic [31:0] wd_o;
  logic [2:0] sdiv_o, best_o;
  logic wv_i = 1'b0;
  logic [31:0] w_i = '0;
  logic sdone_i = 1'b0, spass_i = 1'b0;
  logic [NV*32-1:0] var_o;

  always #10 clk = ~clk;

  clkcal_seq #(.NUM_VAR(NV), .READ_IDX(RIDX), .REGION_BYTES(RB), .THRESH(TH),
               .MIN_DIV(MIND), .WIDE_MASK(1'b1), .FREQ_W(FW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .bus_mhz_i(bus_i),
    .dev_max_mhz_i(max_i), .ctrl_var_i(var_i), .ctrl_wr_o(wr_o),
    .ctrl_wdata_o(wd_o), .cap_req_o(cap_o), .word_valid_i(wv_i), .word_i(w_i),
    .search_start_o(sst_o), .search_div_o(sdiv_o), .search_done_i(sdone_i),
    .search_pass_i(spass_i), .ctrl_var_o(var_o), .busy_o(busy_o), .done_o(done_o),
    .cal_ok_o(ok_o), .too_uniform_o(uni_o), .no_div_o(nod_o), .best_div_o(best_o));

  int n_chk = 0, n_fail = 0;
  logic [31:0] wlog [16];
  int wn = 0;
  int slog [8];
  int sn = 0;
  logic [5:0] pmask_g = '0;

  task automatic chk(input bit c, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!c) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] code(input int d);
    case (d)
      1: code = 4'hF; 2: code = 4'h7; 3: code = 4'hE;
      4: code = 4'h6; 5: code = 4'hD; default: code = 4'h0;
    endcase
  endfunction

  // log controller writes and searches
  always @(negedge clk) begin
    if (wr_o && wn < 16) begin wlog[wn] = wd_o; wn++; end
    if (sst_o && sn < 8) begin slog[sn] = int'(sdiv_o); sn++; end
  end

  // delay-search responder
  initial begin
    forever begin
      @(negedge clk);
      if (sst_o) begin
        automatic int d = int'(sdiv_o);
        @(negedge clk); @(negedge clk);
        sdone_i = 1'b1; spass_i = pmask_g[d];
        @(negedge clk);
        sdone_i = 1'b0; spass_i = 1'b0;
      end
    end
  end

  task automatic run_cal(input int bus, input int mx, input logic [5:0] pm,
                         input int k, input bit poke, input int pre, input int id);
    logic [31:0] vin [NV];
    logic [31:0] vexp [NV];
    logic [31:0] ew [16];
    int es [8];
    int ewn = 0, esn = 0, best = 0, lim;
    for (int i = 0; i < NV; i++) begin
      vin[i] = 32'h1234_5A3C ^ (32'(id) * 32'h0101_0103) ^ (32'(i) * 32'h1111_1111);
      var_i[i*32 +: 32] = vin[i];
      vexp[i] = vin[i];
    end
    bus_i = FW'(bus); max_i = FW'(mx); pmask_g = pm;
    // expected sequence
    ew[ewn++] = vin[RIDX] & MASK;
    if (k < TH) begin
      ew[ewn++] = vin[RIDX];
    end else begin
      for (int d = 5; d >= MIND; d--) begin
        if (mx * d >= bus) begin
          ew[ewn++] = (vin[RIDX] & MASK) | (32'(code(d)) << 8);
          es[esn++] = d;
          if (pm[d]) best = d;
        end
      end
      if (best != 0) begin
        for (int i = 0; i < NV; i++) vexp[i] = (vin[i] & MASK) | (32'(code(best)) << 8);
        ew[ewn++] = vexp[RIDX];
      end else begin
        ew[ewn++] = vin[RIDX];
      end
    end
    // varied words while idle must be ignored (R2)
    for (int i = 0; i < pre; i++) begin
      wv_i = 1'b1; w_i = 32'h3C00_0000 | 32'(i);
      @(negedge clk);
    end
    wv_i = 1'b0;
    wn = 0; sn = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(cap_o === 1'b1, "R1 capture request", 32'(cap_o), 1);
    chk(busy_o === 1'b1, "R9 busy after start", 32'(busy_o), 1);
    for (int n = 0; n < WORDS; n++) begin
      if (n % 5 == 4) begin
        wv_i = 1'b0; w_i = 32'h7777_1234;   // not valid: ignored
        @(negedge clk);
      end
      wv_i = 1'b1;
      w_i = (n < k) ? (32'h5A5A_0000 | 32'(n)) : ((n % 2 == 0) ? 32'h0 : 32'hFFFF_FFFF);
      start_i = poke && (n == 10);
      @(negedge clk);
    end
    wv_i = 1'b0; start_i = 1'b0;
    lim = 0;
    while (!done_o && lim < 3000) begin @(negedge clk); lim++; end
    chk(done_o === 1'b1, "R9 done pulse", 32'(done_o), 1);
    chk(busy_o === 1'b0, "R9 busy low at done", 32'(busy_o), 0);
    chk(uni_o === (k < TH), "R2 R3 too_uniform flag", 32'(uni_o), 32'(k < TH));
    chk(ok_o === (k >= TH && best != 0), "R7 cal_ok flag", 32'(ok_o), 32'(k >= TH && best != 0));
    chk(nod_o === (k >= TH && best == 0), "R8 no_div flag", 32'(nod_o), 32'(k >= TH && best == 0));
    chk(best_o === 3'(best), "R6 best divider", 32'(best_o), 32'(best));
    chk(wn == ewn, "R4 R5 write count", 32'(wn), 32'(ewn));
    for (int i = 0; i < ewn && i < wn; i++)
      chk(wlog[i] === ew[i], (i == 0) ? "R1 first write" : "R4 R7 R8 write value", wlog[i], ew[i]);
    chk(sn == esn, "R5 search count", 32'(sn), 32'(esn));
    for (int i = 0; i < esn && i < sn; i++)
      chk(slog[i] == es[i], "R4 search order", 32'(slog[i]), 32'(es[i]));
    for (int i = 0; i < NV; i++)
      chk(var_o[i*32 +: 32] === vexp[i], "R7 R8 R3 variant out", var_o[i*32 +: 32], vexp[i]);
    @(negedge clk);
    chk(done_o === 1'b0, "R9 done single cycle", 32'(done_o), 0);
  endtask

  bit timeout = 0;

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk(busy_o === 0 && done_o === 0 && wr_o === 0 && cap_o === 0 && sst_o === 0,
            "R9 reset state", {27'b0, busy_o, done_o, wr_o, cap_o, sst_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_cal(200, 250, 6'b111110, 63, 1'b0, 20, 1);   // R2 boundary below, idle words ignored
        run_cal(200, 250, 6'b111110, 64, 1'b0, 0, 2);    // R2 boundary at threshold
        run_cal(200, 250, 6'b111110, 0, 1'b0, 0, 3);     // R3 all uniform
        run_cal(200, 250, 6'b000110, 128, 1'b1, 0, 4);   // R9 start during run
        run_cal(150, 50, 6'b111110, 90, 1'b0, 0, 5);     // R5 equality allowed
        for (int mi = 0; mi < 5; mi++) begin
          for (int m = 0; m < 32; m++) begin
            automatic int mx = (mi == 0) ? 250 : (mi == 1) ? 100 : (mi == 2) ? 50 :
                               (mi == 3) ? 45 : 30;
            run_cal(200, mx, 6'(m << 1), 90, 1'b0, 0, 10 + mi * 32 + m);
          end
        end
      end
      begin
        repeat (190000) @(posedge clk);
        timeout = 1;
      end
    join_any
    disable fork;
    if (timeout) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule